// File: doc/BRIEF.md
# Miss Status Tracker for a Shared Non-Blocking Data Cache

This block keeps track of outstanding misses for a direct-mapped, write-back L1 data cache that many hardware contexts share. A load miss arrives with a context number and a byte address. The block reduces the address to a 64-byte line address. If no tracking entry holds that line, it claims a free entry and sends exactly one refill request to memory. If an entry already tracks the line, the context joins that entry's set of waiters and no further request goes out.

When memory answers, the response names the entry. In that same cycle every waiting context receives a one-cycle wake-up pulse and the entry is released. Store misses go to a small first-in first-out store queue instead of a tracking entry. That queue drains to the memory side through a valid/ready handshake. A load whose line is already held in the store queue counts as a hit on the buffered data and is not tracked. Whenever a miss cannot be accepted, the block raises `full` in the same cycle and the requester retries later.

Top module: `miss_tracker`

## Requirements
- R1: A load miss whose line is in neither the store queue nor any valid entry, arriving while an entry is free, claims the lowest-numbered free entry. In the next cycle `mem_req_valid` is high for one cycle with `mem_req_idx` set to that entry and `mem_req_line` equal to `miss_addr` shifted right by 6.
- R2: A load miss whose line matches a valid entry issues no memory request and adds its context to that entry's waiter set.
- R3: `refill_valid` with the index of a valid entry drives `wake` in that same cycle, with bit c set for every waiting context c. The entry is then free, so a later miss to the same line claims an entry again.
- R4: A load miss that matches the entry being refilled in the same cycle issues no request, and its context is included in that cycle's `wake`.
- R5: A load miss that needs a new entry when all entries are valid sees `full` high in the same cycle and issues no request. Existing entries and their waiters are left unchanged.
- R6: With the default parameters, 16 distinct lines can be tracked at once. A 17th distinct line is refused with `full`.
- R7: A store miss goes into the store queue and never issues a refill request. Once 4 stores are held, a further store sees `full` and is dropped.
- R8: A load miss whose line matches a store held in the queue raises neither `full` nor a memory request, and claims no entry.
- R9: Stores leave the queue oldest first, one per cycle in which `sb_drain_valid` and `sb_drain_ready` are both high. `sb_drain_valid` is low when the queue is empty, and the head holds steady while it waits for `sb_drain_ready`.
- R10: While `rst_n` is low at a clock edge, all entries and the store queue are cleared. `full`, `mem_req_valid`, `wake` and `sb_drain_valid` are then low.
- R11: `refill_valid` naming an entry that is not valid produces an all-zero `wake`.
- R12: Addresses that differ only in their low 6 bits belong to the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_store | input | 1 | 1 = store miss, 0 = load miss |
| miss_ctx | input | CTX_W (3) | Requesting context number |
| miss_addr | input | ADDR_W (32) | Byte address of the miss |
| miss_wdata | input | DATA_W (64) | Store data (store misses only) |
| full | output | 1 | Miss not accepted this cycle, retry |
| mem_req_valid | output | 1 | One-cycle refill request to memory |
| mem_req_idx | output | IDX_W (4) | Entry the refill must name |
| mem_req_line | output | LINE_W (26) | Line address to fetch |
| refill_valid | input | 1 | Refill response this cycle |
| refill_idx | input | IDX_W (4) | Entry the response belongs to |
| wake | output | N_CTX (8) | Per-context wake-up pulse |
| sb_drain_valid | output | 1 | Store queue head is available |
| sb_drain_ready | input | 1 | Memory side takes the head |
| sb_drain_line | output | LINE_W (26) | Line address of the head store |
| sb_drain_data | output | DATA_W (64) | Data of the head store |

## Verification
The assertions check the following on every cycle:
- a refused or store miss is never followed by a refill request, and every request comes from an accepted load;
- a refill releases its entry;
- a refusal leaves the entry set unchanged;
- a waiting queue head stays stable;
- a wake-up only appears together with a refill response.

Only the bench scenarios can show that:
- merged contexts really end up in the right wake mask;
- a miss that lands on a line being refilled is woken at once;
- the lowest free entry is reused after a release;
- load hits in the store queue stay silent;
- the queue drains in its original order.

// File: rtl/miss_pkg.sv
// Shared definitions for the miss tracker.
// Assumes: 64-byte lines, so the line address drops 6 address bits.
package miss_pkg;
    localparam int LINE_OFS_BITS = 6;

    // What happens to the miss presented in the current cycle
    typedef enum logic [2:0] {
        ACT_IDLE   = 3'd0,
        ACT_SBHIT  = 3'd1,
        ACT_MERGE  = 3'd2,
        ACT_ALLOC  = 3'd3,
        ACT_STORE  = 3'd4,
        ACT_REJECT = 3'd5
    } miss_act_e;
endpackage

// File: rtl/miss_first_set.sv
// Finds the lowest set bit of a vector and returns its index.
// Assumes: N >= 2; idx is zero when nothing is set.
module miss_first_set #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top so that the lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/miss_entry_table.sv
// Tracking entries: line address, valid bit and waiter mask per entry.
// Assumes: alloc_idx names a free entry and merge_idx a valid one.
// A refill takes precedence over alloc and merge on the same entry.
module miss_entry_table #(
    parameter int N_ENT  = 16,
    parameter int N_CTX  = 8,
    parameter int LINE_W = 26,
    parameter int IDX_W  = $clog2(N_ENT),
    parameter int CTX_W  = $clog2(N_CTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic              merge_en,
    input  logic [IDX_W-1:0]  merge_idx,
    input  logic              refill_valid,
    input  logic [IDX_W-1:0]  refill_idx,
    output logic [N_ENT-1:0]  match_vec,
    output logic [N_ENT-1:0]  valid_vec,
    output logic [N_CTX-1:0]  wake
);
    logic [LINE_W-1:0] line_q [N_ENT];
    logic [N_CTX-1:0]  wait_q [N_ENT];
    logic [N_ENT-1:0]  valid_q;
    logic [N_CTX-1:0]  ctx_bit;

    assign ctx_bit   = N_CTX'(1) << req_ctx;
    assign valid_vec = valid_q;

    // Per-entry line comparison against the incoming miss
    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        assign match_vec[e] = valid_q[e] && (line_q[e] == lk_line);
    end

    // Entry state update: refill releases, alloc claims, merge adds a waiter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < N_ENT; e++) begin
                line_q[e] <= '0;
                wait_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < N_ENT; e++) begin
                if (refill_valid && refill_idx == IDX_W'(e)) begin
                    valid_q[e] <= 1'b0;
                    wait_q[e]  <= '0;
                end else if (alloc_en && alloc_idx == IDX_W'(e)) begin
                    valid_q[e] <= 1'b1;
                    line_q[e]  <= lk_line;
                    wait_q[e]  <= ctx_bit;
                end else if (merge_en && merge_idx == IDX_W'(e)) begin
                    wait_q[e]  <= wait_q[e] | ctx_bit;
                end
            end
        end
    end

    // Wake-up mask of the refilled entry, plus a same-cycle merger
    always_comb begin
        wake = '0;
        if (refill_valid && valid_q[refill_idx]) begin
            wake = wait_q[refill_idx];
            if (merge_en && merge_idx == refill_idx) begin
                wake = wake | ctx_bit;
            end
        end
    end
endmodule

// File: rtl/miss_store_queue.sv
// First-in first-out store queue with a line lookup port.
// Assumes: push only when not full, pop only when out_valid.
module miss_store_queue #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 26,
    parameter int DATA_W = 64,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic              q_full,
    output logic              out_valid,
    output logic [LINE_W-1:0] head_line,
    output logic [DATA_W-1:0] head_data
);
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  slot_v;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [DEPTH-1:0]  slot_hit;

    // Advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign q_full    = (cnt == CNT_W'(DEPTH));
    assign out_valid = (cnt != '0);
    assign head_line = line_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign lk_hit    = |slot_hit;

    // Per-slot line comparison for load hits on buffered stores
    for (genvar s = 0; s < DEPTH; s++) begin : g_hit
        assign slot_hit[s] = slot_v[s] && (line_q[s] == lk_line);
    end

    // Storage, pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                line_q[s] <= '0;
                data_q[s] <= '0;
            end
        end else begin
            if (push) begin
                line_q[wr_ptr] <= push_line;
                data_q[wr_ptr] <= push_data;
                slot_v[wr_ptr] <= 1'b1;
                wr_ptr         <= nxt(wr_ptr);
            end
            if (pop) begin
                slot_v[rd_ptr] <= 1'b0;
                rd_ptr         <= nxt(rd_ptr);
            end
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/miss_tracker.sv
// Miss tracking for a shared non-blocking direct-mapped L1 data cache.
// Classifies each miss (store, store-queue hit, merge, alloc, reject),
// issues one registered refill request per new line and wakes waiters
// on refill. Assumes the requester retries whenever full is high.
module miss_tracker #(
    parameter int N_CTX    = 8,
    parameter int N_ENT    = 16,
    parameter int N_SB     = 4,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 64,
    parameter int LINE_OFS = miss_pkg::LINE_OFS_BITS,
    parameter int CTX_W    = $clog2(N_CTX),
    parameter int IDX_W    = $clog2(N_ENT),
    parameter int LINE_W   = ADDR_W - LINE_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic              miss_store,
    input  logic [CTX_W-1:0]  miss_ctx,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [DATA_W-1:0] miss_wdata,
    output logic              full,
    output logic              mem_req_valid,
    output logic [IDX_W-1:0]  mem_req_idx,
    output logic [LINE_W-1:0] mem_req_line,
    input  logic              refill_valid,
    input  logic [IDX_W-1:0]  refill_idx,
    output logic [N_CTX-1:0]  wake,
    output logic              sb_drain_valid,
    input  logic              sb_drain_ready,
    output logic [LINE_W-1:0] sb_drain_line,
    output logic [DATA_W-1:0] sb_drain_data
);
    import miss_pkg::*;

    logic [LINE_W-1:0] line;
    logic              unused_ofs;
    logic [N_ENT-1:0]  match_vec, ent_valid;
    logic              hit_found, free_found;
    logic [IDX_W-1:0]  hit_idx, free_idx;
    logic              sq_hit, sq_full;
    miss_act_e         act;

    assign line       = miss_addr[ADDR_W-1:LINE_OFS];
    assign unused_ofs = ^miss_addr[LINE_OFS-1:0];

    miss_first_set #(.N(N_ENT), .W(IDX_W)) u_hit_pick (
        .vec(match_vec), .found(hit_found), .idx(hit_idx)
    );

    miss_first_set #(.N(N_ENT), .W(IDX_W)) u_free_pick (
        .vec(~ent_valid), .found(free_found), .idx(free_idx)
    );

    // Classify the presented miss; store-queue hit has priority over merge
    always_comb begin
        act = ACT_IDLE;
        if (miss_valid) begin
            if (miss_store)      act = sq_full ? ACT_REJECT : ACT_STORE;
            else if (sq_hit)     act = ACT_SBHIT;
            else if (hit_found)  act = ACT_MERGE;
            else if (free_found) act = ACT_ALLOC;
            else                 act = ACT_REJECT;
        end
    end

    assign full = (act == ACT_REJECT);

    miss_entry_table #(
        .N_ENT(N_ENT), .N_CTX(N_CTX), .LINE_W(LINE_W),
        .IDX_W(IDX_W), .CTX_W(CTX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .lk_line(line), .req_ctx(miss_ctx),
        .alloc_en(act == ACT_ALLOC), .alloc_idx(free_idx),
        .merge_en(act == ACT_MERGE), .merge_idx(hit_idx),
        .refill_valid(refill_valid), .refill_idx(refill_idx),
        .match_vec(match_vec), .valid_vec(ent_valid), .wake(wake)
    );

    miss_store_queue #(
        .DEPTH(N_SB), .LINE_W(LINE_W), .DATA_W(DATA_W)
    ) u_sq (
        .clk(clk), .rst_n(rst_n),
        .push(act == ACT_STORE), .push_line(line), .push_data(miss_wdata),
        .pop(sb_drain_valid && sb_drain_ready),
        .lk_line(line), .lk_hit(sq_hit), .q_full(sq_full),
        .out_valid(sb_drain_valid),
        .head_line(sb_drain_line), .head_data(sb_drain_data)
    );

    // One-cycle refill request registered from a fresh allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_idx   <= '0;
            mem_req_line  <= '0;
        end else begin
            mem_req_valid <= (act == ACT_ALLOC);
            if (act == ACT_ALLOC) begin
                mem_req_idx  <= free_idx;
                mem_req_line <= line;
            end
        end
    end
endmodule

// File: rtl/miss_tracker_chk.sv
// Cycle-level properties of miss_tracker, attached by bind.
// Assumes: the top exposes its entry valid vector as ent_valid.
module miss_tracker_chk #(
    parameter int N_CTX  = 8,
    parameter int N_ENT  = 16,
    parameter int DATA_W = 64,
    parameter int LINE_W = 26,
    parameter int IDX_W  = $clog2(N_ENT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_store,
    input logic              full,
    input logic              mem_req_valid,
    input logic              refill_valid,
    input logic [IDX_W-1:0]  refill_idx,
    input logic [N_CTX-1:0]  wake,
    input logic [N_ENT-1:0]  ent_valid,
    input logic              sb_drain_valid,
    input logic              sb_drain_ready,
    input logic [LINE_W-1:0] sb_drain_line,
    input logic [DATA_W-1:0] sb_drain_data
);
    p_req_from_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(miss_valid && !miss_store && !full));

    p_refill_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid && ent_valid[refill_idx] |=> !ent_valid[$past(refill_idx)]);

    p_wake_with_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake) |-> refill_valid);

    p_full_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && full |=> !mem_req_valid);

    p_full_keeps_entries_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && full && !refill_valid |=> ent_valid == $past(ent_valid));

    p_store_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_store |=> !mem_req_valid);

    p_store_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_store && !full |=> sb_drain_valid);

    p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sb_drain_valid && !sb_drain_ready |=>
            sb_drain_valid && $stable(sb_drain_line) && $stable(sb_drain_data));
endmodule

bind miss_tracker miss_tracker_chk #(
    .N_CTX(N_CTX), .N_ENT(N_ENT), .DATA_W(DATA_W),
    .LINE_W(LINE_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_store(miss_store), .full(full),
    .mem_req_valid(mem_req_valid),
    .refill_valid(refill_valid), .refill_idx(refill_idx),
    .wake(wake), .ent_valid(ent_valid),
    .sb_drain_valid(sb_drain_valid), .sb_drain_ready(sb_drain_ready),
    .sb_drain_line(sb_drain_line), .sb_drain_data(sb_drain_data)
);

// File: tb/miss_tracker_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected refill requests and
// drained stores; monitor processes pop and compare them.
module miss_tracker_tb_top;
    localparam int N_CTX = 8, N_ENT = 16, N_SB = 4;
    localparam int ADDR_W = 32, DATA_W = 64;
    localparam int CTX_W = 3, IDX_W = 4, LINE_W = 26;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0, miss_store = 1'b0;
    logic [CTX_W-1:0]  miss_ctx = '0;
    logic [ADDR_W-1:0] miss_addr = '0;
    logic [DATA_W-1:0] miss_wdata = '0;
    logic              full, mem_req_valid;
    logic [IDX_W-1:0]  mem_req_idx;
    logic [LINE_W-1:0] mem_req_line;
    logic              refill_valid = 1'b0;
    logic [IDX_W-1:0]  refill_idx = '0;
    logic [N_CTX-1:0]  wake;
    logic              sb_drain_valid, sb_drain_ready = 1'b0;
    logic [LINE_W-1:0] sb_drain_line;
    logic [DATA_W-1:0] sb_drain_data;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    int                q_idx[$];
    logic [LINE_W-1:0] q_line[$];
    logic [LINE_W-1:0] q_sline[$];
    logic [DATA_W-1:0] q_sdata[$];

    always #2.5 clk = ~clk;

    miss_tracker dut_i (.*);

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input int ctx, input logic [31:0] addr, input bit exp_full,
                        input bit exp_alloc, input int exp_idx, input string req);
        miss_valid = 1'b1; miss_store = 1'b0;
        miss_ctx = CTX_W'(ctx); miss_addr = addr;
        #1;
        chk(full == exp_full, req, full, exp_full);
        if (exp_alloc) begin
            q_idx.push_back(exp_idx);
            q_line.push_back(addr[31:6]);
        end
        go();
        miss_valid = 1'b0;
    endtask

    task automatic store(input logic [31:0] addr, input logic [63:0] data,
                         input bit exp_full, input string req);
        miss_valid = 1'b1; miss_store = 1'b1;
        miss_addr = addr; miss_wdata = data;
        #1;
        chk(full == exp_full, req, full, exp_full);
        if (!exp_full) begin
            q_sline.push_back(addr[31:6]);
            q_sdata.push_back(data);
        end
        go();
        miss_valid = 1'b0; miss_store = 1'b0;
    endtask

    task automatic refill(input int idx, input logic [7:0] exp_wake, input string req);
        refill_valid = 1'b1; refill_idx = IDX_W'(idx);
        #1;
        chk(wake == exp_wake, req, wake, exp_wake);
        go();
        refill_valid = 1'b0;
    endtask

    // Monitor: compare refill requests and drained stores against queues
    always @(negedge clk) begin : mon
        int ei;
        logic [LINE_W-1:0] el;
        logic [DATA_W-1:0] ed;
        if (rst_n && !finished) begin
            if (mem_req_valid) begin
                if (q_idx.size() == 0) begin
                    chk(1'b0, "R1 unexpected request", mem_req_line, 0);
                end else begin
                    ei = q_idx.pop_front();
                    el = q_line.pop_front();
                    chk(mem_req_idx == IDX_W'(ei) && mem_req_line == el, "R1 request",
                        {34'd0, mem_req_idx, mem_req_line}, {34'd0, 4'(ei), el});
                end
            end
            if (sb_drain_valid && sb_drain_ready) begin
                if (q_sline.size() == 0) begin
                    chk(1'b0, "R9 unexpected drain", sb_drain_data, 0);
                end else begin
                    el = q_sline.pop_front();
                    ed = q_sdata.pop_front();
                    chk(sb_drain_line == el && sb_drain_data == ed, "R9 drain order",
                        sb_drain_data, ed);
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #200000;
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) go();
        // R10: reset state
        chk(full == 1'b0, "R10 full", full, 0);
        chk(mem_req_valid == 1'b0, "R10 mem_req_valid", mem_req_valid, 0);
        chk(wake == '0, "R10 wake", wake, 0);
        chk(sb_drain_valid == 1'b0, "R10 sb_drain_valid", sb_drain_valid, 0);
        rst_n = 1'b1;
        go();

        load(0, 32'h0000_1000, 0, 1, 0, "R1 first alloc");
        load(1, 32'h0000_1010, 0, 0, 0, "R2 R12 merge same line");
        load(2, 32'h0000_2000, 0, 1, 1, "R1 second alloc");
        refill(0, 8'b0000_0011, "R3 wake merged waiters");
        refill(0, 8'h00, "R11 refill of free entry");
        load(3, 32'h0000_1000, 0, 1, 0, "R3 line reallocates lowest free");

        // R4: miss on the line being refilled joins the wake
        miss_valid = 1'b1; miss_store = 1'b0; miss_ctx = 3'd4; miss_addr = 32'h0000_2020;
        refill_valid = 1'b1; refill_idx = 4'd1;
        #1;
        chk(wake == 8'b0001_0100, "R4 same-cycle wake", wake, 8'b0001_0100);
        chk(full == 1'b0, "R4 full", full, 0);
        go();
        miss_valid = 1'b0; refill_valid = 1'b0;
        chk(mem_req_valid == 1'b0, "R4 no request", mem_req_valid, 0);

        // R6: fill every entry
        for (int i = 1; i < N_ENT; i++) begin
            load(i % 8, (32'h100 + i) << 6, 0, 1, i, "R6 fill");
        end
        load(5, 32'h300 << 6, 1, 0, 0, "R6 R5 17th line refused");
        chk(mem_req_valid == 1'b0, "R5 no request when full", mem_req_valid, 0);
        load(6, (32'h105 << 6) | 32'h3f, 0, 0, 0, "R12 R2 merge while table full");
        refill(5, 8'b0110_0000, "R2 R12 wake merged");
        refill(0, 8'b0000_1000, "R5 existing entry untouched");
        load(7, 32'h300 << 6, 0, 1, 0, "R1 retry after release");

        // R7: store queue fills
        for (int k = 0; k < N_SB; k++) begin
            store((32'h200 + k) << 6, 64'hA0 + k, 0, "R7 store accepted");
        end
        store(32'h204 << 6, 64'hFF, 1, "R7 fifth store refused");
        chk(sb_drain_valid == 1'b1, "R7 queue holds stores", sb_drain_valid, 1);
        load(1, (32'h202 << 6) | 32'h4, 0, 0, 0, "R8 load hits queued store");
        chk(mem_req_valid == 1'b0, "R8 no request", mem_req_valid, 0);

        // R9: drain in order
        sb_drain_ready = 1'b1;
        repeat (6) go();
        sb_drain_ready = 1'b0;
        chk(sb_drain_valid == 1'b0, "R9 empty after drain", sb_drain_valid, 0);

        go();
        chk(q_idx.size() == 0, "R1 all requests seen", q_idx.size(), 0);
        chk(q_sline.size() == 0, "R9 all stores drained", q_sline.size(), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule